// File: doc/BRIEF.md
# Byte-Cell Memory with Endian Word Access

This block is a single-port synchronous memory of 8-bit cells. Each request names a byte address and reads or writes either one byte or one 16-bit word. A word occupies two neighbouring cells, the cell at the request address and the one after it. A byte-order input picks which half of the word goes into which cell. In little-endian order the low half sits at the request address. In big-endian order the high half sits there. Single bits inside a cell are never addressed on their own.

The address width is a parameter. At a width of 16 the block covers a 64K-byte space. The default is kept small so that the array stays modest when the block is elaborated with its defaults. Addresses wrap at the top of the space, so a word whose first byte is the last cell takes its second byte from cell zero. Internally the cells are split into an even-address bank and an odd-address bank, so both bytes of a word are reached in the same cycle at any alignment. Read data comes from a register and appears one cycle after the request.

Top module: `endianByteMem`

## Requirements
- R1: A byte write stores wrData[7:0] in the one addressed cell. A byte read returns that cell in rdData[7:0] with rdData[15:8] = 0.
- R2: For a read request at a clock edge, rdData and rdValid change at that same edge and hold through the following cycle. rdValid is 1 only in the cycle after a read request and 0 after a write or idle cycle.
- R3: A little-endian word write (bigEndian = 0) at address A stores wrData[7:0] in cell A and wrData[15:8] in cell A+1.
- R4: A big-endian word write (bigEndian = 1) at address A stores wrData[15:8] in cell A and wrData[7:0] in cell A+1.
- R5: A word read at A returns {cell A+1, cell A} when bigEndian = 0 and {cell A, cell A+1} when bigEndian = 1, at either address parity.
- R6: The second byte of a word access at the highest address uses cell 0, because addresses wrap modulo the size of the space.
- R7: A cell keeps its contents until it is written. A byte write changes exactly one cell and a word write changes exactly two cells.
- R8: rdData keeps its last value in cycles that follow a write or an idle cycle.
- R9: While rst_n is low, rdValid and rdData are 0. Cell contents are not reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset of the read-side registers |
| reqValid | input | 1 | A request is present this cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqWord | input | 1 | 1 = 16-bit word access, 0 = single byte |
| bigEndian | input | 1 | Byte order for word access, 1 = big-endian |
| reqAddr | input | ADDR_W | Byte address of the first cell |
| wrData | input | 16 | Write data; only bits 7:0 are used for a byte write |
| rdData | output | 16 | Registered read data |
| rdValid | output | 1 | rdData holds the result of the previous cycle's read |

## Verification
The checker watches the read handshake on every cycle: rdValid follows a read request by exactly one cycle, rdData holds after writes and idle cycles, a byte read clears the upper half, two identical reads in a row return the same value, and the same word read in both orders comes back byte-swapped. Where each byte lands in the cells, the wrap at the top address, and the fact that neighbouring cells stay untouched can only be shown by the bench. It keeps a byte-level model, fills every cell, mixes random accesses of both sizes, orders and parities, and reads back single cells after directed word writes.

// File: rtl/ebmPkg.sv
package ebmPkg;

  // Per-request strobes from the control to the datapath
  typedef struct packed {
    logic evenWe;    // write the even-address bank
    logic oddWe;     // write the odd-address bank
    logic rdEn;      // capture a read this cycle
    logic firstOdd; // first byte of the access lives in the odd bank
    logic bigOrder;  // most significant byte goes to the first address
    logic wordOp;    // two-byte access
  } ebmStrobes_t;

endpackage

// File: rtl/ebmBank.sv
module ebmBank #(
  parameter int ROW_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic             re,
  input  logic [ROW_W-1:0] row,
  input  logic [7:0]       wdata,
  output logic [7:0]       q
);
  localparam int ROWS = 1 << ROW_W;

  logic [7:0] cells [ROWS];

  // Cell array: no reset, contents persist until written
  always_ff @(posedge clk) begin
    if (we) cells[row] <= wdata;
  end

  // Registered read port, updated only on a read
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (re) q <= cells[row];
  end
endmodule

// File: rtl/ebmControl.sv
module ebmControl
  import ebmPkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic              reqWord,
  input  logic              bigEndian,
  input  logic [ADDR_W-1:0] reqAddr,
  output ebmStrobes_t       strobes,
  output logic [ADDR_W-2:0] evenRow,
  output logic [ADDR_W-2:0] oddRow,
  output logic              rdValid
);
  localparam int ROW_W = ADDR_W - 1;

  logic [ROW_W-1:0] baseRow;
  logic             isWrite;

  assign baseRow = reqAddr[ADDR_W-1:1];
  assign isWrite = reqValid && reqWrite;

  always_comb begin
    strobes          = '0;
    strobes.firstOdd = reqAddr[0];
    strobes.bigOrder = bigEndian;
    strobes.wordOp   = reqWord;
    strobes.rdEn     = reqValid && !reqWrite;
    strobes.evenWe   = isWrite && (!reqAddr[0] || reqWord);
    strobes.oddWe    = isWrite && (reqAddr[0] || reqWord);
  end

  // An odd start puts the second byte in the next even row; the row
  // counter width makes the top address wrap to row zero.
  assign oddRow  = baseRow;
  assign evenRow = reqAddr[0] ? baseRow + ROW_W'(1) : baseRow;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdValid <= 1'b0;
    else        rdValid <= reqValid && !reqWrite;
  end
endmodule

// File: rtl/ebmDatapath.sv
module ebmDatapath
  import ebmPkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ebmStrobes_t       strobes,
  input  logic [ADDR_W-2:0] evenRow,
  input  logic [ADDR_W-2:0] oddRow,
  input  logic [15:0]       wrData,
  output logic [15:0]       rdData
);
  localparam int ROW_W = ADDR_W - 1;
  localparam int BANKS = 2;

  logic [7:0]       firstByte;
  logic [7:0]       secondByte;
  logic             bankWe    [BANKS];
  logic [ROW_W-1:0] bankRow   [BANKS];
  logic [7:0]       bankWdata [BANKS];
  logic [7:0]       bankQ     [BANKS];

  // Byte order: which half of the word goes to the request address
  assign firstByte  = (strobes.wordOp && strobes.bigOrder) ? wrData[15:8] : wrData[7:0];
  assign secondByte = strobes.bigOrder ? wrData[7:0] : wrData[15:8];

  assign bankWe[0]    = strobes.evenWe;
  assign bankWe[1]    = strobes.oddWe;
  assign bankRow[0]   = evenRow;
  assign bankRow[1]   = oddRow;
  assign bankWdata[0] = strobes.firstOdd ? secondByte : firstByte;
  assign bankWdata[1] = strobes.firstOdd ? firstByte  : secondByte;

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    ebmBank #(.ROW_W(ROW_W)) u_bank (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (bankWe[b]),
      .re    (strobes.rdEn),
      .row   (bankRow[b]),
      .wdata (bankWdata[b]),
      .q     (bankQ[b])
    );
  end

  // Steering state captured with the read, used on the next cycle
  logic selOdd, selBig, selWord;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      selOdd  <= 1'b0;
      selBig  <= 1'b0;
      selWord <= 1'b0;
    end else if (strobes.rdEn) begin
      selOdd  <= strobes.firstOdd;
      selBig  <= strobes.bigOrder;
      selWord <= strobes.wordOp;
    end
  end

  logic [7:0] rdFirst, rdSecond;

  assign rdFirst  = selOdd ? bankQ[1] : bankQ[0];
  assign rdSecond = selOdd ? bankQ[0] : bankQ[1];

  always_comb begin
    if (!selWord)    rdData = {8'h00, rdFirst};
    else if (selBig) rdData = {rdFirst, rdSecond};
    else             rdData = {rdSecond, rdFirst};
  end
endmodule

// File: rtl/endianByteMem.sv
module endianByteMem
  import ebmPkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic              reqWord,
  input  logic              bigEndian,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [15:0]       wrData,
  output logic [15:0]       rdData,
  output logic              rdValid
);
  ebmStrobes_t       strobes;
  logic [ADDR_W-2:0] evenRow;
  logic [ADDR_W-2:0] oddRow;

  ebmControl #(.ADDR_W(ADDR_W)) u_control (
    .clk       (clk),
    .rst_n     (rst_n),
    .reqValid  (reqValid),
    .reqWrite  (reqWrite),
    .reqWord   (reqWord),
    .bigEndian (bigEndian),
    .reqAddr   (reqAddr),
    .strobes   (strobes),
    .evenRow   (evenRow),
    .oddRow    (oddRow),
    .rdValid   (rdValid)
  );

  ebmDatapath #(.ADDR_W(ADDR_W)) u_datapath (
    .clk     (clk),
    .rst_n   (rst_n),
    .strobes (strobes),
    .evenRow (evenRow),
    .oddRow  (oddRow),
    .wrData  (wrData),
    .rdData  (rdData)
  );
endmodule

// File: rtl/ebmChecker.sv
module ebmChecker #(
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reqValid,
  input logic              reqWrite,
  input logic              reqWord,
  input logic              bigEndian,
  input logic [ADDR_W-1:0] reqAddr,
  input logic [15:0]       rdData,
  input logic              rdValid
);
  logic isRead;
  assign isRead = reqValid && !reqWrite;

  // R2: a read request is answered in the next cycle
  a_r2_valid_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    isRead |=> rdValid);

  // R2: no valid flag without a read the cycle before
  a_r2_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !isRead |=> !rdValid);

  // R8: read data holds when no read happened
  a_r8_hold_data: assert property (@(posedge clk) disable iff (!rst_n)
    !isRead |=> $stable(rdData));

  // R1: a byte read clears the upper half
  a_r1_byte_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (isRead && !reqWord) |=> (rdData[15:8] == 8'h00));

  // R7: back-to-back identical reads see unchanged cells
  a_r7_repeat_read_same: assert property (@(posedge clk) disable iff (!rst_n)
    (isRead && $past(isRead) && reqWord == $past(reqWord) &&
     bigEndian == $past(bigEndian) && reqAddr == $past(reqAddr))
    |=> $stable(rdData));

  // R5: the same word read in the other order comes back swapped
  a_r5_order_swap: assert property (@(posedge clk) disable iff (!rst_n)
    (isRead && reqWord && $past(isRead) && $past(reqWord) &&
     bigEndian != $past(bigEndian) && reqAddr == $past(reqAddr))
    |=> (rdData == {$past(rdData[7:0]), $past(rdData[15:8])}));

  // R9: reset values of the read side
  always @(posedge clk) begin
    if (!rst_n) a_r9_reset_state: assert (!rdValid && rdData == 16'h0000);
  end
endmodule

bind endianByteMem ebmChecker #(.ADDR_W(ADDR_W)) u_ebmChecker (
  .clk       (clk),
  .rst_n     (rst_n),
  .reqValid  (reqValid),
  .reqWrite  (reqWrite),
  .reqWord   (reqWord),
  .bigEndian (bigEndian),
  .reqAddr   (reqAddr),
  .rdData    (rdData),
  .rdValid   (rdValid)
);

// File: tb/test_endianByteMem.sv
`timescale 1ns/1ps
module test_endianByteMem;
  localparam int ADDR_W = 10;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam logic [ADDR_W-1:0] TOP = ADDR_W'(DEPTH - 1);

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              reqValid = 1'b0;
  logic              reqWrite = 1'b0;
  logic              reqWord = 1'b0;
  logic              bigEndian = 1'b0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic [15:0]       wrData = '0;
  logic [15:0]       rdData;
  logic              rdValid;

  int errors = 0;
  int checks = 0;
  logic [7:0]  model [DEPTH];
  logic [15:0] lastRd = 16'h0000;

  always #5 clk = ~clk;

  endianByteMem #(.ADDR_W(ADDR_W)) i_endianByteMem (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqWord(reqWord), .bigEndian(bigEndian), .reqAddr(reqAddr),
    .wrData(wrData), .rdData(rdData), .rdValid(rdValid)
  );

  function automatic logic [ADDR_W-1:0] nextAddr(logic [ADDR_W-1:0] a);
    return a + ADDR_W'(1);
  endfunction

  function automatic logic [15:0] expWord(logic [ADDR_W-1:0] a, logic big);
    logic [7:0] lo = model[a];
    logic [7:0] hi = model[nextAddr(a)];
    return big ? {lo, hi} : {hi, lo};
  endfunction

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // One request; outputs are sampled 1 ns after the capturing edge
  task automatic doOp(logic wr, logic word, logic big, logic [ADDR_W-1:0] a,
                      logic [15:0] d);
    logic [15:0] exp;
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqWord = word; bigEndian = big;
    reqAddr = a; wrData = d;
    exp = word ? expWord(a, big) : {8'h00, model[a]};
    @(posedge clk);
    #1;
    if (wr) begin
      if (word) begin
        model[a]           = big ? d[15:8] : d[7:0];
        model[nextAddr(a)] = big ? d[7:0]  : d[15:8];
      end else begin
        model[a] = d[7:0];
      end
      check("R2 rdValid low after write", {15'd0, rdValid}, 16'd0);
      check("R8 rdData held after write", rdData, lastRd);
    end else begin
      check("R2 rdValid after read", {15'd0, rdValid}, 16'd1);
      check(word ? "R5 word read" : "R1 byte read", rdData, exp);
      lastRd = rdData;
    end
    reqValid = 1'b0;
  endtask

  task automatic idle();
    @(negedge clk);
    reqValid = 1'b0;
    @(posedge clk);
    #1;
    check("R2 rdValid low when idle", {15'd0, rdValid}, 16'd0);
    check("R8 rdData held when idle", rdData, lastRd);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20250611));
    repeat (3) @(posedge clk);
    #1;
    check("R9 reset rdValid", {15'd0, rdValid}, 16'd0);
    check("R9 reset rdData", rdData, 16'h0000);
    @(negedge clk);
    rst_n = 1'b1;

    // Fill every cell so no read touches an unwritten cell
    for (int i = 0; i < DEPTH; i++) begin
      doOp(1'b1, 1'b0, 1'b0, ADDR_W'(i), 16'($urandom));
    end

    // R3: little-endian placement, checked cell by cell
    doOp(1'b1, 1'b1, 1'b0, 10'h2AC, 16'h0F23);
    doOp(1'b0, 1'b0, 1'b0, 10'h2AC, 16'h0);
    check("R3 low byte at A", rdData, 16'h0023);
    doOp(1'b0, 1'b0, 1'b0, 10'h2AD, 16'h0);
    check("R3 high byte at A+1", rdData, 16'h000F);

    // R4: big-endian placement at an odd address
    doOp(1'b1, 1'b1, 1'b1, 10'h131, 16'hA55B);
    doOp(1'b0, 1'b0, 1'b0, 10'h131, 16'h0);
    check("R4 high byte at A", rdData, 16'h00A5);
    doOp(1'b0, 1'b0, 1'b0, 10'h132, 16'h0);
    check("R4 low byte at A+1", rdData, 16'h005B);

    // R7: neighbours of a word write stay untouched
    doOp(1'b1, 1'b0, 1'b0, 10'h0FF, 16'h0011);
    doOp(1'b1, 1'b0, 1'b0, 10'h102, 16'h0022);
    doOp(1'b1, 1'b1, 1'b0, 10'h100, 16'hBEEF);
    doOp(1'b0, 1'b0, 1'b0, 10'h0FF, 16'h0);
    check("R7 cell below word kept", rdData, 16'h0011);
    doOp(1'b0, 1'b0, 1'b0, 10'h102, 16'h0);
    check("R7 cell above word kept", rdData, 16'h0022);
    // R7: a byte write touches one cell only
    doOp(1'b1, 1'b0, 1'b1, 10'h101, 16'h7744);
    doOp(1'b0, 1'b1, 1'b0, 10'h100, 16'h0);
    check("R7 byte write one cell", rdData, 16'h44EF);

    // R6: wrap at the top address, both orders
    doOp(1'b1, 1'b0, 1'b0, 10'h001, 16'h0099);
    doOp(1'b1, 1'b1, 1'b0, TOP, 16'hC3D4);
    doOp(1'b0, 1'b0, 1'b0, 10'h000, 16'h0);
    check("R6 little-endian wrap into cell 0", rdData, 16'h00C3);
    doOp(1'b0, 1'b0, 1'b0, TOP, 16'h0);
    check("R6 low byte at top cell", rdData, 16'h00D4);
    doOp(1'b1, 1'b1, 1'b1, TOP, 16'h1E2F);
    doOp(1'b0, 1'b0, 1'b0, 10'h000, 16'h0);
    check("R6 big-endian wrap into cell 0", rdData, 16'h002F);
    doOp(1'b0, 1'b1, 1'b0, TOP, 16'h0);
    check("R6 word read across wrap", rdData, 16'h2F1E);
    doOp(1'b0, 1'b0, 1'b0, 10'h001, 16'h0);
    check("R7 cell 1 kept after wrap", rdData, 16'h0099);

    // R5: same word in both orders, back to back
    doOp(1'b0, 1'b1, 1'b0, 10'h2AC, 16'h0);
    check("R5 little-endian word", rdData, 16'h0F23);
    doOp(1'b0, 1'b1, 1'b1, 10'h2AC, 16'h0);
    check("R5 big-endian word", rdData, 16'h230F);
    idle();

    // Random mix; reads are checked inside doOp against the model
    for (int i = 0; i < 4000; i++) begin
      logic [3:0] pick = 4'($urandom);
      logic [ADDR_W-1:0] a = (pick == 4'hF) ? TOP : ADDR_W'($urandom);
      if (pick == 4'hE) idle();
      else doOp(pick[0], pick[1], pick[2], a, 16'($urandom));
    end

    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R9 rdValid cleared by reset", {15'd0, rdValid}, 16'd0);
    check("R9 rdData cleared by reset", rdData, 16'h0000);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule